// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block drives the outgoing half of a five-wire time-division audio link from the controller side. It runs on the bit clock that the codec supplies and emits a continuous stream of 256-bit frames on one serial data line, together with the frame synchronisation strobe. The frames repeat at 48 kHz with a 12.288 MHz bit clock.

Each frame opens with a 16-bit tag. The tag holds a frame-valid flag, one valid flag for each of the twelve 20-bit data slots that follow, and a 3-bit codec identifier. The block fills four of those slots. A register-access command goes into slots 1 and 2. A stereo pair of 16-bit playback samples goes into slots 3 and 4. All other slots are sent as zero and marked invalid.

A command is offered on a level-held request and is taken at the next frame start, with a one-cycle acknowledge. Samples are fetched through a once-per-frame request pulse. The supplier loads a stereo pair into a holding register, and the pair goes out in the next frame that starts after it was loaded.

Top module: `link_frame_tx`

## Requirements
- R1: The output repeats every 256 bit clocks. Within each frame, `sync_o` is high for bit times 0 to 15 (the tag) and low for bit times 16 to 255.
- R2: While `rst_ni` is low, `sync_o`, `sdata_o`, `cmd_ack_o` and `pcm_req_o` are low. The first rising edge after release drives bit 0 of a frame.
- R3: Tag bit 15 is set exactly when any slot valid flag is set. Tag bits 14 down to 3 are the valid flags of slots 1 to 12 in that order. Tag bits 2 to 0 carry the `CODEC_ID` parameter.
- R4: In a frame that carries a command, slot 1 holds the read flag in bit 19 (1 = read), the 7-bit register index in bits 18 to 12, and zeros in bits 11 to 0. Tag bits 14 and 13 are set.
- R5: In a frame that carries a command, slot 2 holds the 16-bit command data in bits 19 to 4, with bits 3 to 0 zero.
- R6: `cmd_valid_i` is sampled at the rising edge that drives bit 0. When it is high there, `cmd_ack_o` pulses for exactly that one cycle. When it is low, slots 1 and 2 and their tag flags are zero.
- R7: `pcm_req_o` pulses for one cycle with bit 0 of every frame, and at no other time.
- R8: A pair loaded with `pcm_valid_i` goes out in the next frame that starts after the load. That frame has left in slot 3 and right in slot 4, each in bits 19 to 4 with bits 3 to 0 zero, and tag bits 12 and 11 set. The pair is sent only once. If no new pair is loaded, the next frame sends slots 3 and 4 as zero and invalid.
- R9: Every field goes out most significant bit first. Slot n (1 to 12) starts at bit time 16 + 20·(n−1).
- R10: Slots 5 to 12 are always zero, so `sdata_o` is low from bit time 96 to 255, and their tag flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock from the codec |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command pending, held until acknowledged |
| cmd_rd_i | input | 1 | 1 = register read, 0 = write |
| cmd_idx_i | input | 7 | Register index |
| cmd_wdata_i | input | 16 | Command data for slot 2 |
| cmd_ack_o | output | 1 | Command taken into the frame now starting |
| pcm_req_o | output | 1 | Once-per-frame request for the next stereo pair |
| pcm_valid_i | input | 1 | Load strobe for the stereo pair |
| pcm_left_i | input | 16 | Left playback sample |
| pcm_right_i | input | 16 | Right playback sample |
| sync_o | output | 1 | Frame sync, high during the tag |
| sdata_o | output | 1 | Serial frame data, changing on the rising edge |

## Verification
The serial stream is captured whole and compared field by field against frames built in the bench. The stimuli are:
- an idle frame, which shows that the tag carries only the codec identifier;
- a write and a read command, whose opposite read flags and extreme indices separate bit-19 placement from index placement;
- a sample pair with alternating edge bits (0x8001/0x7FFE), which exposes shifted or swapped channels;
- a combined command and sample frame, which checks that the valid flags do not interfere;
- the frame after a sample frame, which shows that a pair is sent once and then falls back to invalid.

The timing of the acknowledge and request pulses is checked against the first tag bit.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
  localparam int unsigned FRAME_BITS = 256;
  localparam int unsigned TAG_BITS   = 16;
  localparam int unsigned SLOT_BITS  = 20;
  localparam int unsigned NUM_SLOTS  = 12;
  localparam int unsigned USED_SLOTS = 4;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ID_W       = 3;
  localparam int unsigned SHIFT_BITS = TAG_BITS + USED_SLOTS * SLOT_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  // 16-bit payload left-justified in a 20-bit slot
  function automatic logic [SLOT_BITS-1:0] pack_word(input logic [DATA_W-1:0] d);
    return {d, {(SLOT_BITS-DATA_W){1'b0}}};
  endfunction
endpackage

// File: rtl/link_bit_counter.sv
module link_bit_counter
  import link_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             tag_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (cnt_q == CNT_W'(FRAME_BITS - 1))   cnt_q <= '0;
    else                                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = (cnt_q == '0);
  assign tag_o   = (cnt_q < CNT_W'(TAG_BITS));
endmodule

// File: rtl/link_sample_hold.sv
module link_sample_hold
  import link_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              take_i,
  output logic              have_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  logic              have_q;
  logic [DATA_W-1:0] left_q, right_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      if (load_i) begin
        have_q  <= 1'b1;
        left_q  <= left_i;
        right_q <= right_i;
      end else if (take_i) begin
        have_q  <= 1'b0;
      end
    end
  end

  assign have_o  = have_q;
  assign left_o  = left_q;
  assign right_o = right_q;
endmodule

// File: rtl/link_frame_builder.sv
module link_frame_builder
  import link_tx_pkg::*;
#(
  parameter logic [ID_W-1:0] CODEC_ID = '0
) (
  input  logic                  cmd_vld_i,
  input  logic                  cmd_rd_i,
  input  logic [IDX_W-1:0]      cmd_idx_i,
  input  logic [DATA_W-1:0]     cmd_wdata_i,
  input  logic                  pcm_vld_i,
  input  logic [DATA_W-1:0]     pcm_left_i,
  input  logic [DATA_W-1:0]     pcm_right_i,
  output logic [SHIFT_BITS-1:0] frame_o
);
  localparam int unsigned PAD_W = SLOT_BITS - 1 - IDX_W;

  logic [NUM_SLOTS-1:0] slot_vld;  // index 0 = slot 1
  logic [TAG_BITS-1:0]  tag;
  logic [SLOT_BITS-1:0] s_addr, s_data, s_left, s_right;

  always_comb begin
    slot_vld    = '0;
    slot_vld[0] = cmd_vld_i;
    slot_vld[1] = cmd_vld_i;
    slot_vld[2] = pcm_vld_i;
    slot_vld[3] = pcm_vld_i;
  end

  assign tag[TAG_BITS-1] = |slot_vld;
  assign tag[ID_W-1:0]   = CODEC_ID;
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_tag
    assign tag[TAG_BITS-2-k] = slot_vld[k];
  end

  assign s_addr  = cmd_vld_i ? {cmd_rd_i, cmd_idx_i, {PAD_W{1'b0}}} : '0;
  assign s_data  = cmd_vld_i ? pack_word(cmd_wdata_i) : '0;
  assign s_left  = pcm_vld_i ? pack_word(pcm_left_i)  : '0;
  assign s_right = pcm_vld_i ? pack_word(pcm_right_i) : '0;

  assign frame_o = {tag, s_addr, s_data, s_left, s_right};
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
  import link_tx_pkg::*;
#(
  parameter logic [ID_W-1:0] CODEC_ID = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ack_o,
  output logic              pcm_req_o,
  input  logic              pcm_valid_i,
  input  logic [DATA_W-1:0] pcm_left_i,
  input  logic [DATA_W-1:0] pcm_right_i,
  output logic              sync_o,
  output logic              sdata_o
);
  logic [CNT_W-1:0]      bit_cnt;
  logic                  start, in_tag;
  logic                  have_pair;
  logic [DATA_W-1:0]     hold_l, hold_r;
  logic [SHIFT_BITS-1:0] frame, shreg_q;

  link_bit_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (bit_cnt),
    .start_o (start),
    .tag_o   (in_tag)
  );

  link_sample_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pcm_valid_i),
    .left_i  (pcm_left_i),
    .right_i (pcm_right_i),
    .take_i  (start),
    .have_o  (have_pair),
    .left_o  (hold_l),
    .right_o (hold_r)
  );

  link_frame_builder #(.CODEC_ID(CODEC_ID)) u_build (
    .cmd_vld_i   (cmd_valid_i),
    .cmd_rd_i    (cmd_rd_i),
    .cmd_idx_i   (cmd_idx_i),
    .cmd_wdata_i (cmd_wdata_i),
    .pcm_vld_i   (have_pair),
    .pcm_left_i  (hold_l),
    .pcm_right_i (hold_r),
    .frame_o     (frame)
  );

  // outputs change on the rising edge; codec samples on the falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      sdata_o   <= 1'b0;
      sync_o    <= 1'b0;
      cmd_ack_o <= 1'b0;
      pcm_req_o <= 1'b0;
    end else begin
      sync_o    <= in_tag;
      cmd_ack_o <= start & cmd_valid_i;
      pcm_req_o <= start;
      if (start) begin
        sdata_o <= frame[SHIFT_BITS-1];
        shreg_q <= {frame[SHIFT_BITS-2:0], 1'b0};
      end else begin
        sdata_o <= shreg_q[SHIFT_BITS-1];
        shreg_q <= {shreg_q[SHIFT_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/link_frame_tx_chk.sv
module link_frame_tx_chk
  import link_tx_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ack_o,
  input logic pcm_req_o,
  input logic sync_o,
  input logic sdata_o
);
  logic [CNT_W-1:0] edges_q;
  logic             started_q;
  logic [CNT_W-1:0] bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q   <= '0;
      started_q <= 1'b0;
    end else begin
      edges_q   <= (edges_q == CNT_W'(FRAME_BITS - 1)) ? '0 : edges_q + 1'b1;
      started_q <= 1'b1;
    end
  end

  // bit time currently on the outputs
  assign bit_idx = (edges_q == '0) ? CNT_W'(FRAME_BITS - 1) : edges_q - 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !sync_o && !sdata_o && !cmd_ack_o && !pcm_req_o); // R2
  AST_SYNC_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> sync_o == (bit_idx < CNT_W'(TAG_BITS))); // R1
  AST_ACK_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> started_q && bit_idx == '0 && $past(cmd_valid_i)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |=> !cmd_ack_o); // R6
  AST_REQ_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_req_o |-> started_q && bit_idx == '0); // R7
  AST_REQ_EVERY_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && bit_idx == '0 |-> pcm_req_o); // R7
  AST_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && bit_idx >= CNT_W'(TAG_BITS + USED_SLOTS * SLOT_BITS) |-> !sdata_o); // R10
endmodule

bind link_frame_tx link_frame_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ack_o   (cmd_ack_o),
  .pcm_req_o   (pcm_req_o),
  .sync_o      (sync_o),
  .sdata_o     (sdata_o)
);

// File: tb/link_frame_tx_test.sv
`timescale 1ns/1ps
module link_frame_tx_test;
  localparam logic [2:0] ID = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0]  cmd_idx = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ack, pcm_req;
  logic        pcm_valid = 1'b0;
  logic [15:0] pcm_l = '0, pcm_r = '0;
  logic        sync, sdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  link_frame_tx #(.CODEC_ID(ID)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_rd_i(cmd_rd), .cmd_idx_i(cmd_idx),
    .cmd_wdata_i(cmd_wdata), .cmd_ack_o(cmd_ack), .pcm_req_o(pcm_req),
    .pcm_valid_i(pcm_valid), .pcm_left_i(pcm_l), .pcm_right_i(pcm_r),
    .sync_o(sync), .sdata_o(sdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [255:0] fr;
  bit ack0, req0;
  int sync_bad, pulse_bad;

  // capture one frame starting at the next sync rise; bit i = bit time i
  task automatic capture();
    sync_bad = 0; pulse_bad = 0;
    do @(negedge clk); while (sync);
    do @(negedge clk); while (!sync);
    ack0 = cmd_ack; req0 = pcm_req;
    if (cmd_ack) cmd_valid = 1'b0;
    fr[0] = sdata;
    for (int i = 1; i < 256; i++) begin
      @(negedge clk);
      fr[i] = sdata;
      if (sync != (i < 16)) sync_bad++;
      if (cmd_ack || pcm_req) pulse_bad++;
    end
  endtask

  function automatic logic [31:0] field(input int start, input int len);
    logic [31:0] v = '0;
    for (int i = 0; i < len; i++) v = {v[30:0], fr[start+i]};
    return v;
  endfunction

  task automatic verify(input bit cv, input bit rd, input logic [6:0] idx, input logic [15:0] wd,
                        input bit pv, input logic [15:0] l, input logic [15:0] r, input string tag);
    logic [15:0] et;
    logic [31:0] tail;
    et = {cv | pv, cv, cv, pv, pv, 8'h00, ID};
    chk(sync_bad == 0, {"R1 sync shape ", tag}, sync_bad, 0);
    chk(field(0, 16) == {16'h0, et}, {"R3 tag ", tag}, field(0, 16), et);
    chk(field(16, 20) == (cv ? {12'h0, rd, idx, 12'h000} : 32'h0), {"R4 slot1 ", tag},
        field(16, 20), cv ? {12'h0, rd, idx, 12'h000} : 32'h0);
    chk(field(36, 20) == (cv ? {12'h0, wd, 4'h0} : 32'h0), {"R5 slot2 ", tag},
        field(36, 20), cv ? {12'h0, wd, 4'h0} : 32'h0);
    chk(field(56, 20) == (pv ? {12'h0, l, 4'h0} : 32'h0), {"R8 R9 slot3 ", tag},
        field(56, 20), pv ? {12'h0, l, 4'h0} : 32'h0);
    chk(field(76, 20) == (pv ? {12'h0, r, 4'h0} : 32'h0), {"R8 R9 slot4 ", tag},
        field(76, 20), pv ? {12'h0, r, 4'h0} : 32'h0);
    tail = 0;
    for (int i = 96; i < 256; i++) tail += fr[i];
    chk(tail == 0, {"R10 tail ", tag}, tail, 0);
    chk(ack0 == cv, {"R6 ack at start ", tag}, ack0, cv);
    chk(req0 && pulse_bad == 0, {"R7 req once ", tag}, {req0, 31'(pulse_bad)}, 32'h8000_0000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!sync && !sdata && !cmd_ack && !pcm_req, "R2 reset quiet",
        {sync, sdata, cmd_ack, pcm_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync && pcm_req, "R2 first edge is bit 0", {sync, pcm_req}, 2'b11);
  endtask

  task automatic t_idle();
    capture();
    verify(0, 0, '0, '0, 0, '0, '0, "idle");
  endtask

  task automatic issue_cmd(input bit rd, input logic [6:0] idx, input logic [15:0] wd);
    repeat (20) @(negedge clk);
    cmd_rd = rd; cmd_idx = idx; cmd_wdata = wd; cmd_valid = 1'b1;
  endtask

  task automatic load_pair(input logic [15:0] l, input logic [15:0] r);
    repeat (20) @(negedge clk);
    pcm_l = l; pcm_r = r; pcm_valid = 1'b1;
    @(negedge clk);
    pcm_valid = 1'b0; pcm_l = '0; pcm_r = '0;
  endtask

  task automatic t_write();
    issue_cmd(0, 7'h2A, 16'hBEEF);
    capture();
    verify(1, 0, 7'h2A, 16'hBEEF, 0, '0, '0, "write");
    capture();
    verify(0, 0, '0, '0, 0, '0, '0, "after write");
  endtask

  task automatic t_read();
    issue_cmd(1, 7'h7F, 16'h0000);
    capture();
    verify(1, 1, 7'h7F, 16'h0000, 0, '0, '0, "read");
  endtask

  task automatic t_pcm();
    load_pair(16'h8001, 16'h7FFE);
    capture();
    verify(0, 0, '0, '0, 1, 16'h8001, 16'h7FFE, "pcm");
    capture();
    verify(0, 0, '0, '0, 0, '0, '0, "pcm consumed");
  endtask

  task automatic t_combined();
    issue_cmd(0, 7'h01, 16'h5A3C);
    load_pair(16'hFFFF, 16'h1234);
    capture();
    verify(1, 0, 7'h01, 16'h5A3C, 1, 16'hFFFF, 16'h1234, "combined");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle();
        t_write();
        t_read();
        t_pcm();
        t_combined();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule